// File: doc/BRIEF.md
# DRAM Power-Down Entry and Exit Sequencer

This block owns the clock-enable pin of a DDR DRAM interface. It lowers clock enable only when the controller asks for power-down and no memory access is still completing. Reads and writes use different completion rules. A read is finished once its postamble-done indication arrives. A write is finished once a programmable number of recovery cycles has elapsed since the write was issued. If the request arrives while an access is in flight, the block first waits in a drain state and then enters power-down.

When clock enable falls, the block records the kind of power-down from the bank status sampled at that moment. The mode is precharge power-down if every bank is idle and active power-down if any row is open. The time spent with clock enable low is bounded by a programmable refresh budget. When the budget runs out the block leaves power-down by itself, even if the request is still held.

Every exit follows the same order. First comes one cycle with clock enable high and a forced no-operation. Then one further cycle with commands still blocked. Only after that does the command-allowed flag return. The command scheduler issues reads, writes and other commands only while command-allowed is high.

Top module: `dram_pd_ctrl`

## Requirements
- R1: After reset, clock enable is high, command-allowed is high, the forced no-operation is low and the active-mode flag is low.
- R2: When a request is sampled with no access in flight, clock enable is low and command-allowed is low from the next cycle.
- R3: The active-mode flag reads 1 (active power-down) while clock enable is low if the bank-idle input was 0 at the entry edge. It reads 0 (precharge power-down) if that input was 1. The flag holds its value while clock enable stays low, and reads 0 whenever clock enable is high.
- R4: When a write issue and the request are sampled in the same cycle, with recovery count W, clock enable stays high for W+1 cycles after that cycle and falls in the one after.
- R5: After a read issue, clock enable stays high until the postamble-done input is sampled high. It is low in the cycle after that sample.
- R6: When the request is released, clock enable rises in the next cycle. In that cycle the forced no-operation is 1 and command-allowed is 0.
- R7: In the cycle after the forced no-operation, command-allowed is still 0 and clock enable is high. In the cycle after that, command-allowed is 1.
- R8: While the request stays high, clock enable stays low for exactly max(B,1) consecutive cycles, where B is the refresh budget. It then rises through the R6/R7 exit sequence.
- R9: If the request is released while draining, the block returns to the command-allowed state in the next cycle without lowering clock enable.
- R10: Clock enable is never low while a read is pending or while write recovery is still counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Power-down request, level |
| banks_idle | input | 1 | 1 when every bank is precharged |
| rd_issue | input | 1 | Strobe: read command issued this cycle |
| wr_issue | input | 1 | Strobe: write command issued this cycle |
| rd_post_done | input | 1 | Strobe: read postamble of the pending read finished |
| wr_rec_cycles | input | 4 | Write-recovery length in cycles |
| ref_budget | input | 16 | Maximum consecutive cycles with clock enable low |
| cke | output | 1 | Clock-enable level to the DRAM |
| pd_mode_active | output | 1 | 1 for active power-down, 0 for precharge power-down |
| force_nop | output | 1 | Forces a no-operation or deselect command this cycle |
| cmd_allow | output | 1 | Scheduler may issue a command this cycle |

## Verification
The assertions assume that the scheduler respects command-allowed, so no read or write strobe arrives while it is low. They also assume that the refresh budget and the recovery count are not changed during power-down. The stimulus keeps to this by issuing every read and write in a cycle where command-allowed is high. The configuration inputs are changed only while the block sits in its command-allowed state. Each scenario drives its inputs on the falling edge and samples the outputs on the following falling edge, so that each rising-edge transition is observed exactly once.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_PD      = 3'd2,
    ST_EXIT    = 3'd3,
    ST_RECOVER = 3'd4
  } pd_state_t;
endpackage

// File: rtl/pdc_access_track.sv
module pdc_access_track #(
  parameter int WR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic            wr_issue,
  input  logic            rd_post_done,
  input  logic [WR_W-1:0] wr_rec_cycles,
  output logic            access_busy,
  output logic            rd_pend,
  output logic            wr_pend
);
  logic            rd_pend_q, rd_pend_d;
  logic [WR_W-1:0] wr_cnt_q, wr_cnt_d;

  always_comb begin
    rd_pend_d = rd_pend_q;
    if (rd_issue)          rd_pend_d = 1'b1;
    else if (rd_post_done) rd_pend_d = 1'b0;
  end

  always_comb begin
    wr_cnt_d = wr_cnt_q;
    if (wr_issue)              wr_cnt_d = wr_rec_cycles;
    else if (wr_cnt_q != '0)   wr_cnt_d = wr_cnt_q - WR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      wr_cnt_q  <= '0;
    end else begin
      rd_pend_q <= rd_pend_d;
      wr_cnt_q  <= wr_cnt_d;
    end
  end

  assign rd_pend     = rd_pend_q;
  assign wr_pend     = (wr_cnt_q != '0);
  assign access_busy = rd_issue | wr_issue | (rd_pend_q & ~rd_post_done) | wr_pend;

  // R4
  wr_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_issue && wr_cnt_q != '0) |=> (wr_cnt_q == $past(wr_cnt_q) - WR_W'(1)));
endmodule

// File: rtl/pdc_dwell_limit.sv
module pdc_dwell_limit #(
  parameter int BUD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_pd,
  input  logic             in_pd,
  input  logic [BUD_W-1:0] ref_budget,
  output logic             expire
);
  logic [BUD_W-1:0] dwell_q, dwell_d;
  logic             cnt_en;

  assign cnt_en = enter_pd | (in_pd & ~(&dwell_q));

  always_comb begin
    dwell_d = dwell_q;
    if (enter_pd)   dwell_d = BUD_W'(1);
    else if (in_pd) dwell_d = dwell_q + BUD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dwell_q <= '0;
    else if (cnt_en) dwell_q <= dwell_d;
  end

  assign expire = in_pd & (dwell_q >= ref_budget);

  // R8
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd |-> (dwell_q <= ref_budget || dwell_q == BUD_W'(1)));
endmodule

// File: rtl/pdc_seq_fsm.sv
module pdc_seq_fsm
  import pdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic busy,
  input  logic expire,
  input  logic banks_idle,
  output logic enter_pd,
  output logic in_pd,
  output logic cke,
  output logic force_nop,
  output logic cmd_allow,
  output logic pd_mode_active
);
  pd_state_t state_q, state_d;
  logic      mode_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ACTIVE:  if (pd_req) state_d = busy ? ST_DRAIN : ST_PD;
      ST_DRAIN:   if (!pd_req)   state_d = ST_ACTIVE;
                  else if (!busy) state_d = ST_PD;
      ST_PD:      if (!pd_req || expire) state_d = ST_EXIT;
      ST_EXIT:    state_d = ST_RECOVER;
      ST_RECOVER: state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
  end

  assign enter_pd = (state_d == ST_PD) && (state_q != ST_PD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACTIVE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= 1'b0;
    else if (enter_pd) mode_q <= ~banks_idle;
  end

  assign in_pd          = (state_q == ST_PD);
  assign cke            = ~in_pd;
  assign force_nop      = (state_q == ST_EXIT);
  assign cmd_allow      = (state_q == ST_ACTIVE);
  assign pd_mode_active = in_pd & mode_q;

  // R6
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (force_nop && !cmd_allow));
  // R7
  recover_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_nop |=> (cke && !force_nop && !cmd_allow));
  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$past(cke)) |-> $stable(pd_mode_active));
endmodule

// File: rtl/dram_pd_ctrl.sv
module dram_pd_ctrl #(
  parameter int WR_W  = 4,
  parameter int BUD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             banks_idle,
  input  logic             rd_issue,
  input  logic             wr_issue,
  input  logic             rd_post_done,
  input  logic [WR_W-1:0]  wr_rec_cycles,
  input  logic [BUD_W-1:0] ref_budget,
  output logic             cke,
  output logic             pd_mode_active,
  output logic             force_nop,
  output logic             cmd_allow
);
  logic busy, rd_pend, wr_pend, expire, enter_pd, in_pd;

  pdc_access_track #(.WR_W(WR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .wr_issue(wr_issue),
    .rd_post_done(rd_post_done), .wr_rec_cycles(wr_rec_cycles),
    .access_busy(busy), .rd_pend(rd_pend), .wr_pend(wr_pend)
  );

  pdc_dwell_limit #(.BUD_W(BUD_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .enter_pd(enter_pd), .in_pd(in_pd),
    .ref_budget(ref_budget), .expire(expire)
  );

  pdc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .busy(busy), .expire(expire),
    .banks_idle(banks_idle), .enter_pd(enter_pd), .in_pd(in_pd), .cke(cke),
    .force_nop(force_nop), .cmd_allow(cmd_allow), .pd_mode_active(pd_mode_active)
  );

  // R10
  no_access_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!rd_pend && !wr_pend));
endmodule

// File: tb/dram_pd_ctrl_tb.sv
module dram_pd_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        pd_req, banks_idle, rd_issue, wr_issue, rd_post_done;
  logic [3:0]  wr_rec_cycles;
  logic [15:0] ref_budget;
  logic        cke, pd_mode_active, force_nop, cmd_allow;
  int          n_chk = 0;
  int          n_fail = 0;

  dram_pd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .banks_idle(banks_idle),
    .rd_issue(rd_issue), .wr_issue(wr_issue), .rd_post_done(rd_post_done),
    .wr_rec_cycles(wr_rec_cycles), .ref_budget(ref_budget),
    .cke(cke), .pd_mode_active(pd_mode_active), .force_nop(force_nop),
    .cmd_allow(cmd_allow)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic settle();
    pd_req = 1'b0;
    repeat (20) tick();
  endtask

  task automatic t_reset();
    check("R1 cke", cke, 1);
    check("R1 cmd_allow", cmd_allow, 1);
    check("R1 force_nop", force_nop, 0);
    check("R1 mode", pd_mode_active, 0);
  endtask

  task automatic t_precharge_entry_exit();
    banks_idle = 1'b1; pd_req = 1'b1;
    tick();
    check("R2 cke low", cke, 0);
    check("R2 cmd_allow low", cmd_allow, 0);
    check("R3 precharge mode", pd_mode_active, 0);
    pd_req = 1'b0;
    tick();
    check("R6 cke high", cke, 1);
    check("R6 force_nop", force_nop, 1);
    check("R6 cmd_allow", cmd_allow, 0);
    tick();
    check("R7 cke", cke, 1);
    check("R7 nop cleared", force_nop, 0);
    check("R7 cmd still blocked", cmd_allow, 0);
    tick();
    check("R7 cmd_allow back", cmd_allow, 1);
    settle();
  endtask

  task automatic t_active_mode();
    banks_idle = 1'b0; pd_req = 1'b1;
    tick();
    check("R3 active mode", pd_mode_active, 1);
    banks_idle = 1'b1;
    tick();
    check("R3 mode held", pd_mode_active, 1);
    pd_req = 1'b0;
    tick();
    check("R3 mode zero when cke high", pd_mode_active, 0);
    settle();
  endtask

  task automatic t_write(input int w);
    int n = 0;
    int first_low = -1;
    wr_rec_cycles = 4'(w);
    wr_issue = 1'b1; pd_req = 1'b1;
    for (int i = 1; i <= w + 4; i++) begin
      tick();
      wr_issue = 1'b0;
      n = i;
      if (first_low < 0 && cke == 1'b0) first_low = n;
    end
    check("R4 write recovery cke fall", first_low, w + 2);
    settle();
  endtask

  task automatic t_read();
    rd_issue = 1'b1; pd_req = 1'b1;
    tick();
    rd_issue = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R5 cke held during read", cke, 1);
      tick();
    end
    rd_post_done = 1'b1;
    tick();
    rd_post_done = 1'b0;
    check("R5 cke low after postamble", cke, 0);
    settle();
  endtask

  task automatic t_budget(input int b);
    int lows = 0;
    int exp_lows = (b < 1) ? 1 : b;
    ref_budget = 16'(b);
    pd_req = 1'b1;
    tick();
    while (cke == 1'b0 && lows < 50) begin
      lows++;
      tick();
    end
    check("R8 low duration", lows, exp_lows);
    check("R8 forced exit nop", force_nop, 1);
    tick();
    check("R8 recover blocked", cmd_allow, 0);
    tick();
    check("R8 active window", cmd_allow, 1);
    tick();
    check("R8 re-entry with request held", cke, 0);
    settle();
    ref_budget = 16'd1000;
  endtask

  task automatic t_drain_abort();
    wr_rec_cycles = 4'd10;
    wr_issue = 1'b1; pd_req = 1'b1;
    tick();
    wr_issue = 1'b0;
    check("R9 draining blocks commands", cmd_allow, 0);
    check("R10 cke high while write recovers", cke, 1);
    tick();
    pd_req = 1'b0;
    tick();
    check("R9 back to active", cmd_allow, 1);
    check("R9 cke never fell", cke, 1);
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; pd_req = 1'b0; banks_idle = 1'b1; rd_issue = 1'b0;
    wr_issue = 1'b0; rd_post_done = 1'b0; wr_rec_cycles = 4'd0;
    ref_budget = 16'd1000;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_precharge_entry_exit();
    t_active_mode();
    t_write(3);
    t_write(0);
    t_write(15);
    t_read();
    t_budget(4);
    t_budget(0);
    t_drain_abort();
    report();
  end
endmodule